// File: doc/BRIEF.md
# Serial-Controlled Clock Output Gate

This block sits between a set of free-running clock sources and the pins that carry them off chip. A host writes a 16-bit mode word over a three-wire serial port: a bit clock, a latch strobe and a data line. The block checks that the word is well formed before it accepts it. Five bits of an accepted word decide which of five clock groups may pass to their outputs. A group whose bit is clear drives its outputs low. Two of the groups drive two pins each, so there are seven gated outputs.

The serial lines are oversampled in the system clock domain. The shift register and the enable register live in that domain. Each enable bit then crosses into the clock domain of its own source through a synchroniser. The final gate flop is loaded while the source clock is low, so switching a group on or off never produces a shortened pulse. After reset every group runs.

Top module: `ser_clk_gate`

## Requirements
- R1: A frame is shifted in most significant bit first, one bit on each rising edge of `ser_ck_i` while `ser_le_i` is low. The rising edge of `ser_le_i` commits the frame. Without a commit the enable register keeps its value.
- R2: A committed frame is accepted only if bits 15..10 equal 011100. Any other value leaves every output state unchanged.
- R3: Bit 9 and bits 3..0 are reserved and must be zero. A frame whose signature matches but whose reserved bits are not all zero is rejected as a whole.
- R4: A frame is accepted only if exactly 16 bit-clock rising edges arrived while the strobe was low. A frame with 15 or with 17 edges is discarded.
- R5: Bit 4 enables group 0 (`src_clk_i[0]` to `clk_o[1:0]`). Bit 5 enables group 1 (`src_clk_i[1]` to `clk_o[2]`). Bit 6 enables group 2 (`src_clk_i[2]` to `clk_o[3]`). Bit 7 enables group 3 (`src_clk_i[3]` to `clk_o[5:4]`). Bit 8 enables group 4 (`src_clk_i[4]` to `clk_o[6]`).
- R6: Once the change has settled, an output whose group bit is 1 equals its source clock, and an output whose group bit is 0 stays low.
- R7: After reset all five group bits are 1 and every output follows its source.
- R8: A gated output only rises together with a rising edge of its source and only falls together with a falling edge of its source. No runt pulse appears when a group is switched.
- R9: Bit-clock edges while `ser_le_i` is high shift nothing and count toward no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial port |
| rst | input | 1 | Synchronous active-high reset, applied in every domain |
| ser_ck_i | input | 1 | Serial bit clock |
| ser_le_i | input | 1 | Latch strobe: low while shifting, rising edge commits |
| ser_dat_i | input | 1 | Serial data, MSB first |
| src_clk_i | input | 5 | Free-running source clock of each group |
| clk_o | output | 7 | Gated clock outputs |

## Verification
The bench uses the default of two synchroniser stages in both the serial sampler and the output crossings. With that depth, every change settles within a few source periods, so a short fixed settle window covers the latency. The five source clocks run at unrelated half-periods from 5 ns to 9 ns, with a fractional phase offset from the 250 MHz system clock. The gate therefore switches at many different phases, and each edge of every output can be checked against the edge of its source. The frames cover valid words of several enable patterns and the rejection cases: a bad signature, reserved bits set, 15 and 17 bits, and bits clocked while the strobe is high.

// File: rtl/ser_clk_gate_pkg.sv
`timescale 1ns/1ps
package ser_clk_gate_pkg;
    localparam int FRAME_W = 16;
    localparam int NUM_GRP = 5;
    localparam int NUM_OUT = 7;
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [5:0] SIGNATURE = 6'b011100;

    typedef struct packed {
        logic [5:0]         sig;
        logic               rsv_hi;
        logic [NUM_GRP-1:0] en;
        logic [3:0]         rsv_lo;
    } mode_word_t;

    function automatic logic word_ok(mode_word_t w);
        return (w.sig == SIGNATURE) && !w.rsv_hi && (w.rsv_lo == 4'd0);
    endfunction

    function automatic int grp_of(int o);
        case (o)
            0, 1:    return 0;
            2:       return 1;
            3:       return 2;
            4, 5:    return 3;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/ser_rx.sv
`timescale 1ns/1ps
module ser_rx
    import ser_clk_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_ck_i,
    input  logic             ser_le_i,
    input  logic             ser_dat_i,
    output logic             done_o,
    output logic [FRAME_W-1:0] word_o,
    output logic [CNT_W-1:0] cnt_o
);
    // sample bits: [2] bit clock, [1] strobe, [0] data
    logic [2:0] sq [SYNC_STAGES];
    logic       ck_prev, le_prev;
    logic       ck_s, le_s, dat_s;
    logic       ck_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) sq[i] <= 3'b111;
        end else begin
            sq[0] <= {ser_ck_i, ser_le_i, ser_dat_i};
            for (int i = 1; i < SYNC_STAGES; i++) sq[i] <= sq[i-1];
        end
    end

    assign ck_s  = sq[SYNC_STAGES-1][2];
    assign le_s  = sq[SYNC_STAGES-1][1];
    assign dat_s = sq[SYNC_STAGES-1][0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_prev <= 1'b1;
            le_prev <= 1'b1;
        end else begin
            ck_prev <= ck_s;
            le_prev <= le_s;
        end
    end

    assign ck_rise = ck_s && !ck_prev;
    assign done_o  = le_s && !le_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
            cnt_o  <= '0;
        end else if (le_s) begin
            cnt_o <= '0;
        end else if (ck_rise) begin
            word_o <= {word_o[FRAME_W-2:0], dat_s};
            if (cnt_o != CNT_W'(CNT_MAX)) cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/ctl_reg.sv
`timescale 1ns/1ps
module ctl_reg
    import ser_clk_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               done_i,
    input  logic [FRAME_W-1:0] word_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output logic [NUM_GRP-1:0] en_o
);
    mode_word_t w;
    logic       accept;

    assign w      = mode_word_t'(word_i);
    assign accept = done_i && (cnt_i == CNT_W'(FRAME_W)) && word_ok(w);

    always_ff @(posedge clk) begin
        if (rst)         en_o <= '1;
        else if (accept) en_o <= w.en;
    end
endmodule

// File: rtl/clk_gate.sv
`timescale 1ns/1ps
module clk_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic rst,
    input  logic en_i,
    output logic clk_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   gate_q;

    always_ff @(posedge src_clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], en_i};
    end

    // loaded while the source is low, so the AND below cannot clip a pulse
    always_ff @(negedge src_clk) begin
        if (rst) gate_q <= 1'b1;
        else     gate_q <= sync_q[SYNC_STAGES-1];
    end

    assign clk_o = src_clk & gate_q;
endmodule

// File: rtl/ser_clk_gate.sv
`timescale 1ns/1ps
module ser_clk_gate
    import ser_clk_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_ck_i,
    input  logic               ser_le_i,
    input  logic               ser_dat_i,
    input  logic [NUM_GRP-1:0] src_clk_i,
    output logic [NUM_OUT-1:0] clk_o
);
    logic               rx_done;
    logic [FRAME_W-1:0] rx_word;
    logic [CNT_W-1:0]   rx_cnt;
    logic [NUM_GRP-1:0] en_q;
    logic [NUM_GRP-1:0] grp_clk;

    ser_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst),
        .ser_ck_i(ser_ck_i), .ser_le_i(ser_le_i), .ser_dat_i(ser_dat_i),
        .done_o(rx_done), .word_o(rx_word), .cnt_o(rx_cnt)
    );

    ctl_reg u_ctl (
        .clk(clk), .rst(rst),
        .done_i(rx_done), .word_i(rx_word), .cnt_i(rx_cnt),
        .en_o(en_q)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .src_clk(src_clk_i[g]), .rst(rst),
            .en_i(en_q[g]), .clk_o(grp_clk[g])
        );
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        assign clk_o[o] = grp_clk[grp_of(o)];
    end
endmodule

// File: rtl/ser_clk_gate_chk.sv
`timescale 1ns/1ps
module ser_clk_gate_chk
    import ser_clk_gate_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               done,
    input logic [FRAME_W-1:0] word,
    input logic [CNT_W-1:0]   cnt,
    input logic [NUM_GRP-1:0] en
);
    assert_hold_without_commit_R1: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(en));

    assert_bad_signature_R2: assert property (@(posedge clk) disable iff (rst)
        (done && word[15:10] != 6'b011100) |=> $stable(en));

    assert_reserved_reject_R3: assert property (@(posedge clk) disable iff (rst)
        (done && (word[9] || word[3:0] != 4'd0)) |=> $stable(en));

    assert_bit_count_R4: assert property (@(posedge clk) disable iff (rst)
        (done && cnt != CNT_W'(16)) |=> $stable(en));

    assert_field_map_R5: assert property (@(posedge clk) disable iff (rst)
        (done && cnt == CNT_W'(16) && word[15:10] == 6'b011100 && !word[9] && word[3:0] == 4'd0)
        |=> en == $past(word[8:4]));

    assert_reset_all_on_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> en == '1);
endmodule

bind ser_clk_gate ser_clk_gate_chk u_chk (
    .clk(clk), .rst(rst), .done(rx_done), .word(rx_word), .cnt(rx_cnt), .en(en_q)
);

// File: tb/ser_clk_gate_tb.sv
`timescale 1ns/1ps
module ser_clk_gate_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_ck = 1'b0;
    logic       ser_le = 1'b1;
    logic       ser_dat = 1'b1;
    logic [4:0] src;
    logic [6:0] clk_o;

    int    total = 0;
    int    bad = 0;
    int    settle = 1000;
    int    cycles = 0;
    bit    started = 0;
    bit    finished = 0;
    logic [4:0] exp_en = 5'b11111;
    string cur_req = "R7";

    always #2 clk = ~clk;

    for (genvar g = 0; g < 5; g++) begin : g_src
        logic sc = 1'b0;
        initial begin
            #1.3;
            forever #(5.0 + g) sc = ~sc;
        end
        assign src[g] = sc;
    end

    ser_clk_gate u_dut (
        .clk(clk), .rst(rst),
        .ser_ck_i(ser_ck), .ser_le_i(ser_le), .ser_dat_i(ser_dat),
        .src_clk_i(src), .clk_o(clk_o)
    );

    function automatic logic [6:0] expect_out(logic [4:0] s, logic [4:0] e);
        logic [4:0] p;
        p = s & e;
        return {p[4], p[3], p[3], p[2], p[1], p[0], p[0]};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (settle > 0) settle--;
        else if (started) begin
            logic [6:0] e;
            e = expect_out(src, exp_en);
            total++;
            if (clk_o !== e) begin
                bad++;
                $display("FAIL %s: clk_o=%b expected %b (en model %b)", cur_req, clk_o, e, exp_en);
            end
        end
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            finish_run();
        end
    end

    // R8: every output edge coincides with a like edge of its source
    for (genvar o = 0; o < 7; o++) begin : g_mon
        localparam int G = (o < 2) ? 0 : (o == 2) ? 1 : (o == 3) ? 2 : (o < 6) ? 3 : 4;
        always @(posedge clk_o[o]) if (started) begin
            total++;
            if (src[G] !== 1'b1) begin
                bad++;
                $display("FAIL R8: out %0d rose with source=%b expected 1", o, src[G]);
            end
        end
        always @(negedge clk_o[o]) if (started) begin
            total++;
            if (src[G] !== 1'b0) begin
                bad++;
                $display("FAIL R8: out %0d fell with source=%b expected 0", o, src[G]);
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: MSB-first shift, commit on strobe rise
    task automatic send(logic [31:0] val, int nbits, string tag, int pre_hi_clocks = 0, logic [31:0] pre_val = 0);
        cur_req = tag;
        for (int i = pre_hi_clocks - 1; i >= 0; i--) begin
            ser_dat = pre_val[i];
            wait_clk(10); ser_ck = 1'b1;
            wait_clk(10); ser_ck = 1'b0;
        end
        wait_clk(10);
        ser_le = 1'b0;
        wait_clk(10);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = val[i];
            wait_clk(10); ser_ck = 1'b1;
            wait_clk(10); ser_ck = 1'b0;
        end
        wait_clk(10);
        ser_le = 1'b1;
        ser_dat = 1'b1;
        if (nbits == 16 && val[15:10] == 6'b011100 && val[9] == 1'b0 && val[3:0] == 4'd0)
            exp_en = val[8:4];
        settle = 60;
        wait_clk(150);
    endtask

    function automatic logic [15:0] mk(logic [4:0] en);
        return {6'b011100, 1'b0, en, 4'b0000};
    endfunction

    initial begin
        wait_clk(20);
        rst = 1'b0;
        settle = 60;
        started = 1;
        wait_clk(100);
        // R7: explicit reset-state check
        total++;
        if (clk_o !== expect_out(src, 5'b11111)) begin
            bad++;
            $display("FAIL R7: clk_o=%b expected %b", clk_o, expect_out(src, 5'b11111));
        end
        send(32'(mk(5'b01110)), 16, "R5");
        send(32'(mk(5'b10001)), 16, "R6");
        send(32'(mk(5'b00000)), 16, "R6");
        send(32'(mk(5'b11111)), 16, "R1");
        send(32'(mk(5'b01010)), 16, "R5");
        send(32'({6'b011101, 1'b0, 5'b10101, 4'b0}), 16, "R2");
        send(32'({6'b111100, 1'b0, 5'b00000, 4'b0}), 16, "R2");
        send(32'({6'b011100, 1'b1, 5'b00000, 4'b0}), 16, "R3");
        send(32'({6'b011100, 1'b0, 5'b11111, 4'b0001}), 16, "R3");
        send(32'(mk(5'b10101)) >> 1, 15, "R4");
        send({15'd0, 1'b1, mk(5'b10101)}, 17, "R4");
        // R9: five bits clocked with strobe high would complete a valid frame
        send(32'({5'b00000, 1'b0, 4'b0000}), 11, "R9", 5, 32'b01110);
        send(32'(mk(5'b11011)), 16, "R5");
        wait_clk(50);
        finish_run();
    end
endmodule